// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-based controller core. Each cycle the surrounding core presents an operation code and the accumulator value. It also presents a second operand, taken from data memory or an immediate field, together with the current carry and half-carry flags. Within the same cycle the block returns the 8-bit result, the next values of the zero, carry, half-carry and overflow flags, and a per-flag write-enable mask. The status register logic uses the mask to decide which flags it commits.

The block is purely combinational. It has no clock, no state and no handshake. Decoding, skip sequencing, the register file and the status register itself belong to the surrounding core. Single-operand operations (decimal adjust, complement, the rotates, increment and decrement) act on the accumulator input and ignore the second operand.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op` are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 decimal adjust, 5 AND, 6 OR, 7 XOR, 8 complement, 9 rotate left, 10 rotate right, 11 rotate left through carry, 12 rotate right through carry, 13 increment, 14 decrement, 15 idle. Add gives `res` = (acc + opnd) mod 256, and add with carry also adds `c_in`. In both cases `c_o` is the carry out of bit 7.
- R2: Subtract gives (acc - opnd) mod 256. Subtract with borrow further subtracts (1 - `c_in`). `c_o` is 1 exactly when no borrow occurred.
- R3: For the four add/subtract codes, `ac_o` is the carry out of bit 3 of the adder that forms acc + operand (or acc + ~operand + carry-in for subtraction). `ov_o` is 1 when the signed two's-complement result falls outside -128..127.
- R4: Decimal adjust adds 0x06 when acc[3:0] > 9 or `ac_in` = 1. It then adds 0x60 when the intermediate high nibble > 9, when the first step carried out of bit 7, or when `c_in` = 1. `c_o` is 1 exactly when the 0x60 step was applied.
- R5: AND, OR and XOR combine acc with opnd bitwise. Complement returns ~acc.
- R6: Rotate left and rotate right turn acc within the byte. The through-carry forms shift `c_in` into the vacated bit. In all four, `c_o` is the bit shifted out.
- R7: Increment and decrement give (acc ± 1) mod 256 and ignore `opnd` and `c_in`.
- R8: `z_o` is 1 exactly when `res` is zero, for every operation that writes Z.
- R9: `flag_we` bits are [3] OV, [2] Z, [1] AC, [0] C. The values are: add/subtract 4'b1111, decimal adjust 4'b0101, logic and increment/decrement 4'b0100, rotates 4'b0001. Each flag output whose mask bit is 0 is driven 0.
- R10: Code 15 gives `res` = 0 and `flag_we` = 0. Single-operand operations give the same outputs whatever `opnd` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (R1) |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Memory or immediate operand |
| c_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current half-carry flag |
| res | output | 8 | Operation result |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| ac_o | output | 1 | Next half-carry flag |
| ov_o | output | 1 | Next overflow flag |
| flag_we | output | 4 | Per-flag write enable, [3] OV, [2] Z, [1] AC, [0] C |

## Verification
The bench drives every code with every operand pair that matters and both values of each incoming flag. It compares each result against integer arithmetic.

Several corner cases are targeted directly:
- Subtract with borrow at acc = opnd and `c_in` = 0. A design with the borrow sense inverted reports carry set and the wrong result.
- Half-carry on subtraction. A design that takes bit 4 of a plain difference disagrees on nibble-equal operands.
- Decimal adjust where the low-nibble fix ripples into a high nibble of 0xA or beyond 0xFF. A design that tests the high nibble before the first step misses the second correction.
- The masks and the zeroed unwritten flags. A leaked flag shows up on rotates and logic operations.

// File: rtl/alu8_pkg.sv
`timescale 1ns/10ps
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_DAA = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_CPL = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11,
    OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  // flag vector positions
  localparam int FB_C  = 0;
  localparam int FB_AC = 1;
  localparam int FB_Z  = 2;
  localparam int FB_OV = 3;
  localparam int NFLAG = 4;

  function automatic logic [NFLAG-1:0] flag_mask(alu_op_e o);
    case (o)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC:          flag_mask = 4'b1111;
      OP_DAA:                                  flag_mask = 4'b0101;
      OP_AND, OP_OR, OP_XOR, OP_CPL,
      OP_INC, OP_DEC:                          flag_mask = 4'b0100;
      OP_RL, OP_RR, OP_RLC, OP_RRC:            flag_mask = 4'b0001;
      default:                                 flag_mask = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/10ps
// Two-stage nibble adder: exposes half-carry, carry and signed overflow.
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co,
  output logic         hc,
  output logic         ov
);
  localparam int H = W / 2;
  localparam int U = W - H;

  logic [H:0] lo;
  logic [U:0] hi;

  always_comb begin
    lo  = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, ci};
    hi  = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{U{1'b0}}, lo[H]};
    sum = {hi[U-1:0], lo[H-1:0]};
    co  = hi[U];
    hc  = lo[H];
    ov  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_decadj.sv
`timescale 1ns/10ps
// Decimal correction of the accumulator after a packed-BCD addition.
module alu8_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         c_in,
  input  logic         ac_in,
  output logic [W-1:0] r,
  output logic         c_out
);
  localparam int H = W / 2;
  localparam logic [W-1:0] FIX_LO = W'(6);
  localparam logic [W-1:0] FIX_HI = W'(6) << H;
  localparam logic [W-H-1:0] NINE_HI = (W-H)'(9);
  localparam logic [H-1:0]   NINE_LO = H'(9);

  logic         lo_fix;
  logic         hi_fix;
  logic [W:0]   mid;

  always_comb begin
    lo_fix = (a[H-1:0] > NINE_LO) || ac_in;
    mid    = {1'b0, a} + {1'b0, (lo_fix ? FIX_LO : '0)};
    hi_fix = (mid[W-1:H] > NINE_HI) || mid[W] || c_in;
    r      = mid[W-1:0] + (hi_fix ? FIX_HI : '0);
    c_out  = hi_fix;
  end

  always_comb begin
    if (!$isunknown({a, c_in, ac_in})) begin
      // R4: with no fix needed anywhere, the byte passes through unchanged
      assert_daa_passthru_R4: assert (!(a[H-1:0] <= NINE_LO && a[W-1:H] <= NINE_HI && !c_in && !ac_in) || (r == a && !c_out));
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/10ps
// Bitwise logic and rotate group.
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] r,
  output logic         co
);
  always_comb begin
    r  = '0;
    co = 1'b0;
    case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_CPL: r = ~a;
      OP_RL:  begin r = {a[W-2:0], a[W-1]}; co = a[W-1]; end
      OP_RR:  begin r = {a[0], a[W-1:1]};   co = a[0];   end
      OP_RLC: begin r = {a[W-2:0], ci};     co = a[W-1]; end
      OP_RRC: begin r = {ci, a[W-1:1]};     co = a[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/10ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]       op,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     opnd,
  input  logic             c_in,
  input  logic             ac_in,
  output logic [W-1:0]     res,
  output logic             z_o,
  output logic             c_o,
  output logic             ac_o,
  output logic             ov_o,
  output logic [NFLAG-1:0] flag_we
);
  alu_op_e      opc;
  logic [W-1:0] add_y, add_s, daa_r, bit_r;
  logic         add_ci, add_co, add_hc, add_ov, daa_c, bit_co;
  logic [NFLAG-1:0] raw;

  assign opc = alu_op_e'(op);

  // effective adder operands
  always_comb begin
    add_y  = '0;
    add_ci = 1'b0;
    case (opc)
      OP_ADD: begin add_y = opnd;  add_ci = 1'b0; end
      OP_ADC: begin add_y = opnd;  add_ci = c_in; end
      OP_SUB: begin add_y = ~opnd; add_ci = 1'b1; end
      OP_SBC: begin add_y = ~opnd; add_ci = c_in; end
      OP_INC: begin add_y = '0;    add_ci = 1'b1; end
      OP_DEC: begin add_y = '1;    add_ci = 1'b0; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_add (
    .x(acc), .y(add_y), .ci(add_ci),
    .sum(add_s), .co(add_co), .hc(add_hc), .ov(add_ov)
  );

  alu8_decadj #(.W(W)) u_daa (
    .a(acc), .c_in(c_in), .ac_in(ac_in), .r(daa_r), .c_out(daa_c)
  );

  alu8_bitops #(.W(W)) u_bit (
    .op(opc), .a(acc), .b(opnd), .ci(c_in), .r(bit_r), .co(bit_co)
  );

  always_comb begin
    res = '0;
    raw = '0;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        res        = add_s;
        raw[FB_C]  = add_co;
        raw[FB_AC] = add_hc;
        raw[FB_OV] = add_ov;
      end
      OP_DAA: begin
        res       = daa_r;
        raw[FB_C] = daa_c;
      end
      OP_NOP: res = '0;
      default: begin
        res       = bit_r;
        raw[FB_C] = bit_co;
      end
    endcase
    raw[FB_Z] = (res == '0);
    flag_we   = flag_mask(opc);
    c_o       = raw[FB_C]  & flag_we[FB_C];
    ac_o      = raw[FB_AC] & flag_we[FB_AC];
    z_o       = raw[FB_Z]  & flag_we[FB_Z];
    ov_o      = raw[FB_OV] & flag_we[FB_OV];
  end

  always_comb begin
    if (!$isunknown({op, acc, opnd, c_in, ac_in})) begin
      assert_add_sum_R1:   assert (opc != OP_ADD || res == W'(acc + opnd));
      assert_sub_borrow_R2: assert (opc != OP_SUB || c_o == (acc >= opnd));
      assert_cpl_inverts_R5: assert (opc != OP_CPL || (res ^ acc) == '1);
      assert_rot_keeps_ones_R6: assert (!(opc == OP_RL || opc == OP_RR) || $countones(res) == $countones(acc));
      assert_inc_step_R7:  assert (opc != OP_INC || W'(res - acc) == W'(1));
      assert_dec_step_R7:  assert (opc != OP_DEC || W'(acc - res) == W'(1));
      assert_rot_c_only_R9: assert (!(opc inside {OP_RL, OP_RR, OP_RLC, OP_RRC}) || (!z_o && !ac_o && !ov_o));
    end
  end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/10ps
module sim_alu8_core;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] op;
  logic [7:0] acc, opnd, res;
  logic       c_in, ac_in, z_o, c_o, ac_o, ov_o;
  logic [3:0] flag_we;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  bit  done  = 1'b0;

  alu8_core u0 (
    .op(op), .acc(acc), .opnd(opnd), .c_in(c_in), .ac_in(ac_in),
    .res(res), .z_o(z_o), .c_o(c_o), .ac_o(ac_o), .ov_o(ov_o), .flag_we(flag_we)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {we[3:0], flags {ov,z,ac,c}, res[7:0]}
  function automatic logic [15:0] model(int o, int a, int b, int ci, int ai);
    int r = 0, c = 0, ac = 0, ov = 0, we = 0, s, k, t;
    case (o)
      0, 1: begin
        k = (o == 1) ? ci : 0;
        s = a + b + k; r = s % 256; c = (s > 255);
        ac = ((a % 16 + b % 16 + k) > 15);
        s = sx(a) + sx(b) + k; ov = (s > 127 || s < -128); we = 15;
      end
      2, 3: begin
        k = (o == 3) ? 1 - ci : 0;
        r = (a - b - k + 512) % 256; c = (a >= b + k);
        ac = ((a % 16) >= (b % 16) + k);
        s = sx(a) - sx(b) - k; ov = (s > 127 || s < -128); we = 15;
      end
      4: begin
        t = a + ((a % 16 > 9 || ai == 1) ? 6 : 0);
        c = ((t / 16) % 16 > 9 || t > 255 || ci == 1);
        r = (t + (c ? 96 : 0)) % 256; we = 5;
      end
      5: begin r = a & b; we = 4; end
      6: begin r = a | b; we = 4; end
      7: begin r = a ^ b; we = 4; end
      8: begin r = 255 - a; we = 4; end
      9:  begin r = (a * 2) % 256 + a / 128; c = a / 128; we = 1; end
      10: begin r = a / 2 + (a % 2) * 128;   c = a % 2;   we = 1; end
      11: begin r = (a * 2) % 256 + ci;      c = a / 128; we = 1; end
      12: begin r = a / 2 + ci * 128;        c = a % 2;   we = 1; end
      13: begin r = (a + 1) % 256;   we = 4; end
      14: begin r = (a + 255) % 256; we = 4; end
      default: begin r = 0; we = 0; end
    endcase
    model[7:0]  = 8'(r);
    model[8]    = (c != 0)  && we[0];
    model[9]    = (ac != 0) && we[1];
    model[10]   = (r == 0)  && we[2];
    model[11]   = (ov != 0) && we[3];
    model[15:12] = 4'(we);
  endfunction

  function automatic string tag(int o, logic [15:0] got, logic [15:0] exp);
    if (o == 15) return "R10";
    if (got[15:12] != exp[15:12]) return "R9";
    if (got[10] != exp[10]) return "R8";
    if (got[9] != exp[9] || got[11] != exp[11]) return "R3";
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R4";
      5, 6, 7, 8: return "R5";
      9, 10, 11, 12: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(int o, int a, int b, int ci, int ai);
    logic [15:0] exp, got;
    op = 4'(o); acc = 8'(a); opnd = 8'(b); c_in = 1'(ci); ac_in = 1'(ai);
    #0.1;
    exp = model(o, a, b, ci, ai);
    got = {flag_we, ov_o, z_o, ac_o, c_o, res};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d acc=%02h opnd=%02h c=%0d ac=%0d actual=%04h expected=%04h",
               tag(o, got, exp), o, a, b, ci, ai, got, exp);
    end
  endtask

  initial begin
    op = 4'd15; acc = '0; opnd = '0; c_in = 0; ac_in = 0;
    repeat (2) @(negedge clk);
    // idle code first (R10)
    check(15, 0, 0, 0, 0);
    check(15, 255, 255, 1, 1);
    // directed corners: borrow sense (R2), DAA ripple (R4)
    check(3, 8'h40, 8'h40, 0, 0);
    check(3, 8'h40, 8'h40, 1, 0);
    check(4, 8'h9A, 0, 0, 0);
    check(4, 8'hFA, 0, 0, 0);
    // exhaustive sweep; unary codes use two opnd values (R10 independence)
    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int ai = 0; ai < 2; ai++) begin
            if (o inside {0, 1, 2, 3, 5, 6, 7}) begin
              for (int b = 0; b < 256; b++) check(o, a, b, ci, ai);
            end else begin
              check(o, a, 8'h00, ci, ai);
              check(o, a, 8'hA5, ci, ai);
            end
          end
        end
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule